// File: doc/BRIEF.md
# SIMD Floating-Point Status and Trap Controller

This block keeps the 32-bit control/status word of a SIMD floating-point unit and decides, for each instruction the execution unit retires, whether the instruction completes or ends in a fault. The execution unit presents one report per instruction. The report carries six exception indications, the access alignment and the processor configuration bits that matter. One cycle later the block presents a one-hot fault code, or zero when the instruction completes.

The word holds the sticky exception flags in bits 0 to 5, in the order invalid, denormal, zero-divide, overflow, underflow, precision. Bit 6 is denormals-are-zero. The exception masks sit in bits 7 to 12, each mask 7 positions above its flag. The rounding control uses bits 13 and 14, flush-to-zero is bit 15 and the misaligned-mode bit is bit 17. A software write replaces the whole word. The arithmetic itself lives elsewhere; this block only records flags and selects the trap.

Top module: `simd_fp_trap_ctrl`

## Requirements
- R1: After reset the word reads 0x0000_1F80, with all six masks set and all flags clear, and the fault code is 0.
- R2: A write replaces bits 0 to 15 and bit 17 with the written data. Bits 16 and 18 to 31 always read 0. If a write and a report fall in the same cycle, the written value wins and that report's flags are not recorded.
- R3: An accepted report ORs its six flags into bits 0 to 5 (invalid = bit 0, denormal = 1, zero-divide = 2, overflow = 3, underflow = 4, precision = 5). No flag is ever cleared except by a write.
- R4: A report made while the feature-present bit is 0, the emulate bit is 1 or the OS save/restore support bit is 0 gives the invalid-opcode fault (code bit 0) and records no flags.
- R5: A report made while the task-switch bit is 1, and no R4 condition holds, gives the device-not-available fault (code bit 1) and records no flags.
- R6: A misaligned report with bit 17 = 0 gives the general-protection fault (code bit 2) and records no flags.
- R7: A misaligned report with bit 17 = 1 and alignment checking enabled gives the alignment-check fault (code bit 3) and records no flags. With alignment checking disabled, the misaligned access raises no alignment fault.
- R8: An exception is unmasked when its report bit is 1 and its mask bit (flag position + 7) is 0. An unmasked exception gives the invalid-opcode fault (code bit 0) when the OS SIMD-exception enable is 0, and the SIMD exception fault (code bit 4) when that enable is 1. In both cases the flags are still recorded. Masked exceptions raise no fault.
- R9: The fault code appears in the cycle after the report and lasts one cycle. It has at most one bit set and is 0 in the cycle after any cycle without a report. The priority, from highest to lowest, is R4, R5, R6, R7, R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rep_valid | input | 1 | One instruction report this cycle |
| rep_flags | input | 6 | Exception indications of the report, bit order as in R3 |
| rep_misaligned | input | 1 | The memory operand is not 16-byte aligned |
| align_chk_en | input | 1 | Alignment checking enabled |
| os_simd_exc_en | input | 1 | OS delivers SIMD exceptions through their own fault |
| emulate_bit | input | 1 | Emulation requested; SIMD instructions fault |
| task_switched | input | 1 | State switched lazily; SIMD use faults |
| os_save_support | input | 1 | OS supports saving the SIMD state |
| feature_present | input | 1 | The SIMD feature is implemented |
| wr_en | input | 1 | Software write of the word |
| wr_data | input | 32 | Value to write |
| csr_q | output | 32 | Current control/status word |
| fault_code | output | 5 | One-hot fault: 0 UD, 1 NM, 2 GP, 3 AC, 4 SIMD |

## Verification
The bench builds the block with its default parameters: six flags, masks 7 positions above their flags, and a reset word with every mask set. That reset value makes the masked path reachable with no write. Clearing single mask bits by writes then brings each unmasked path within reach, under both settings of the OS enable. Setting bit 17 by a write reaches the alignment-check path, and stacking configuration faults over one another exercises each step of the priority chain.

// File: rtl/simd_fp_pkg.sv
// Package: shared field positions and fault encoding of the SIMD FP
// status and trap controller. Assumes the fixed word layout of the brief.
package simd_fp_pkg;

    localparam int FLAG_N   = 6;   // number of exception flags
    localparam int MASK_OFS = 7;   // distance from a flag to its mask
    localparam int MM_BIT   = 17;  // misaligned-mode control bit
    localparam int CSR_W    = 32;

    // Bits that hold state; all others read as zero.
    localparam logic [CSR_W-1:0] CSR_DEFINED = 32'h0002_FFFF;

    // One-hot fault code; FLT_NONE means the instruction completes.
    typedef enum logic [4:0] {
        FLT_NONE = 5'b00000,
        FLT_UD   = 5'b00001,
        FLT_NM   = 5'b00010,
        FLT_GP   = 5'b00100,
        FLT_AC   = 5'b01000,
        FLT_XF   = 5'b10000
    } fault_e;

endpackage

// File: rtl/unmask_detect.sv
// Module: finds report flags whose mask bit is clear.
// Assumes flags and masks are given in the same bit order.
module unmask_detect #(
    parameter int N = 6
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] masks,
    output logic         any_unmasked
);

    logic [N-1:0] hit;

    // One detector per flag position.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign hit[i] = flags[i] & ~masks[i];
    end

    // Reduce the per-flag hits to one request.
    assign any_unmasked = |hit;

endmodule

// File: rtl/fault_arbiter.sv
// Module: selects the single fault for an instruction report in fixed
// priority and registers it for one cycle. Also tells the register
// whether the report reached execution, so that its flags may be recorded.
// Assumes one report per cycle at most; all inputs synchronous to clk.
module fault_arbiter
    import simd_fp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   feature_present,
    input  logic   emulate_bit,
    input  logic   os_save_support,
    input  logic   task_switched,
    input  logic   misaligned,
    input  logic   align_chk_en,
    input  logic   mm_mode,
    input  logic   unmasked,
    input  logic   os_simd_exc_en,
    output logic   accept,
    output fault_e fault_q
);

    logic   cfg_bad;
    logic   gp_hit;
    logic   ac_hit;
    fault_e fault_d;

    assign cfg_bad = ~feature_present | emulate_bit | ~os_save_support;
    assign gp_hit  = misaligned & ~mm_mode;
    assign ac_hit  = misaligned & mm_mode & align_chk_en;

    // Priority chain: configuration, task switch, GP, AC, SIMD exception.
    always_comb begin
        fault_d = FLT_NONE;
        if (req) begin
            if (cfg_bad)            fault_d = FLT_UD;
            else if (task_switched) fault_d = FLT_NM;
            else if (gp_hit)        fault_d = FLT_GP;
            else if (ac_hit)        fault_d = FLT_AC;
            else if (unmasked)      fault_d = os_simd_exc_en ? FLT_XF : FLT_UD;
        end
    end

    // A report reaches execution when nothing stops it before execution.
    assign accept = req & ~cfg_bad & ~task_switched & ~gp_hit & ~ac_hit;

    // Register the selected fault for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= FLT_NONE;
        else        fault_q <= fault_d;
    end

    AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_q)); // R9
    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> fault_q == FLT_NONE); // R9
    AST_TS_GIVES_NM: assert property (@(posedge clk) disable iff (!rst_n)
        req && feature_present && !emulate_bit && os_save_support && task_switched
        |=> fault_q == FLT_NM); // R5
    AST_CFG_GIVES_UD: assert property (@(posedge clk) disable iff (!rst_n)
        req && (!feature_present || emulate_bit || !os_save_support)
        |=> fault_q == FLT_UD); // R4

endmodule

// File: rtl/sfcsr_reg.sv
// Module: the control/status word. A write replaces the defined bits;
// an accepted report ORs its flags into the sticky flag field.
// Assumes the write takes precedence over a same-cycle report.
module sfcsr_reg
    import simd_fp_pkg::*;
#(
    parameter logic [CSR_W-1:0] RESET_VAL = 32'h0000_1F80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    input  logic              acc_en,
    input  logic [FLAG_N-1:0] acc_flags,
    output logic [CSR_W-1:0]  csr_q
);

    logic [CSR_W-1:0] flag_merge;

    assign flag_merge = {{(CSR_W-FLAG_N){1'b0}}, acc_flags};

    // Hold the word: reset, software write, or sticky flag accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n)      csr_q <= RESET_VAL & CSR_DEFINED;
        else if (wr_en)  csr_q <= wr_data & CSR_DEFINED;
        else if (acc_en) csr_q <= csr_q | flag_merge;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~CSR_DEFINED) == '0); // R2
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> csr_q == ($past(wr_data) & CSR_DEFINED)); // R2
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (csr_q[FLAG_N-1:0] & $past(csr_q[FLAG_N-1:0])) == $past(csr_q[FLAG_N-1:0])); // R3
    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(csr_q[CSR_W-1:FLAG_N])); // R3

endmodule

// File: rtl/simd_fp_trap_ctrl.sv
// Module: top of the SIMD FP status and trap controller. Joins the
// status word, the unmasked-exception detector and the fault arbiter.
// Assumes one instruction report per cycle and a fault result one
// cycle later.
module simd_fp_trap_ctrl
    import simd_fp_pkg::*;
#(
    parameter logic [31:0] RESET_VAL = 32'h0000_1F80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rep_valid,
    input  logic [5:0]  rep_flags,
    input  logic        rep_misaligned,
    input  logic        align_chk_en,
    input  logic        os_simd_exc_en,
    input  logic        emulate_bit,
    input  logic        task_switched,
    input  logic        os_save_support,
    input  logic        feature_present,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] csr_q,
    output logic [4:0]  fault_code
);

    logic   unmasked;
    logic   accept;
    fault_e fault_q;

    // Find report flags whose mask is clear in the current word.
    unmask_detect #(.N(FLAG_N)) u_unmask (
        .flags        (rep_flags),
        .masks        (csr_q[MASK_OFS +: FLAG_N]),
        .any_unmasked (unmasked)
    );

    // Choose the fault and whether the report reaches execution.
    fault_arbiter u_arb (
        .clk             (clk),
        .rst_n           (rst_n),
        .req             (rep_valid),
        .feature_present (feature_present),
        .emulate_bit     (emulate_bit),
        .os_save_support (os_save_support),
        .task_switched   (task_switched),
        .misaligned      (rep_misaligned),
        .align_chk_en    (align_chk_en),
        .mm_mode         (csr_q[MM_BIT]),
        .unmasked        (unmasked),
        .os_simd_exc_en  (os_simd_exc_en),
        .accept          (accept),
        .fault_q         (fault_q)
    );

    // Keep the word and its sticky flags.
    sfcsr_reg #(.RESET_VAL(RESET_VAL)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .acc_en    (accept),
        .acc_flags (rep_flags),
        .csr_q     (csr_q)
    );

    assign fault_code = fault_q;

    AST_MISALIGN_GP: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid && rep_misaligned && !csr_q[MM_BIT] && feature_present &&
        !emulate_bit && os_save_support && !task_switched
        |=> fault_code == 5'b00100); // R6
    AST_UNMASKED_XF: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid && ((rep_flags & ~csr_q[12:7]) != 6'd0) && !rep_misaligned &&
        feature_present && !emulate_bit && os_save_support && !task_switched && os_simd_exc_en
        |=> fault_code == 5'b10000); // R8

endmodule

// File: tb/tb_simd_fp_trap_ctrl.sv
module tb_simd_fp_trap_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rep_valid = 1'b0;
    logic [5:0]  rep_flags = '0;
    logic        rep_misaligned = 1'b0;
    logic        align_chk_en = 1'b0;
    logic        os_simd_exc_en = 1'b0;
    logic        emulate_bit = 1'b0;
    logic        task_switched = 1'b0;
    logic        os_save_support = 1'b1;
    logic        feature_present = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] csr_q;
    logic [4:0]  fault_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_fp_trap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_flags(rep_flags),
        .rep_misaligned(rep_misaligned), .align_chk_en(align_chk_en),
        .os_simd_exc_en(os_simd_exc_en), .emulate_bit(emulate_bit),
        .task_switched(task_switched), .os_save_support(os_save_support),
        .feature_present(feature_present), .wr_en(wr_en), .wr_data(wr_data),
        .csr_q(csr_q), .fault_code(fault_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_csr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // One report, then check fault and word one cycle later.
    task automatic report(input logic [5:0] f, input logic [4:0] exp_fault,
                          input logic [31:0] exp_csr, input string tag);
        @(negedge clk); rep_valid = 1'b1; rep_flags = f;
        @(negedge clk); rep_valid = 1'b0; rep_flags = '0;
        chk({tag, " fault"}, {27'd0, fault_code}, {27'd0, exp_fault});
        chk({tag, " csr"}, csr_q, exp_csr);
    endtask

    task automatic t_reset();
        chk("R1 reset csr", csr_q, 32'h0000_1F80);
        chk("R1 reset fault", {27'd0, fault_code}, 32'd0);
    endtask

    task automatic t_write();
        write_csr(32'hFFFF_FFFF);
        chk("R2 reserved zero", csr_q, 32'h0002_FFFF);
        write_csr(32'h0000_1F80);
        chk("R2 write back", csr_q, 32'h0000_1F80);
        // Write and report in the same cycle: write wins.
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h0000_1F80; rep_valid = 1'b1; rep_flags = 6'h3F;
        @(negedge clk); wr_en = 1'b0; rep_valid = 1'b0; rep_flags = '0;
        chk("R2 write beats report", csr_q, 32'h0000_1F80);
    endtask

    task automatic t_sticky();
        report(6'b100001, 5'd0, 32'h0000_1FA1, "R3 masked PE+IE");
        report(6'b000010, 5'd0, 32'h0000_1FA3, "R3 sticky add DE");
        report(6'b000000, 5'd0, 32'h0000_1FA3, "R3 empty report");
        chk("R9 idle no fault", {27'd0, fault_code}, 32'd0);
    endtask

    task automatic t_unmasked();
        write_csr(32'h0000_1D80); // zero-divide mask (bit 9) clear
        os_simd_exc_en = 1'b0;
        report(6'b000100, 5'b00001, 32'h0000_1D84, "R8 unmasked os=0 UD");
        write_csr(32'h0000_1D80);
        os_simd_exc_en = 1'b1;
        report(6'b000100, 5'b10000, 32'h0000_1D84, "R8 unmasked os=1 XF");
        report(6'b000001, 5'd0, 32'h0000_1D85, "R8 masked IE no fault");
        @(negedge clk);
        chk("R9 one-cycle pulse", {27'd0, fault_code}, 32'd0);
    endtask

    task automatic t_config();
        write_csr(32'h0000_1D80);
        emulate_bit = 1'b1;
        report(6'b000100, 5'b00001, 32'h0000_1D80, "R4 emulate UD");
        emulate_bit = 1'b0; feature_present = 1'b0;
        report(6'b000100, 5'b00001, 32'h0000_1D80, "R4 absent UD");
        feature_present = 1'b1; os_save_support = 1'b0;
        report(6'b000001, 5'b00001, 32'h0000_1D80, "R4 no save support UD");
        os_save_support = 1'b1; task_switched = 1'b1;
        report(6'b000100, 5'b00010, 32'h0000_1D80, "R5 task switch NM");
        emulate_bit = 1'b1;
        report(6'b000000, 5'b00001, 32'h0000_1D80, "R9 R4 over R5");
        emulate_bit = 1'b0; task_switched = 1'b0;
    endtask

    task automatic t_align();
        write_csr(32'h0000_1D80);
        rep_misaligned = 1'b1;
        report(6'b000100, 5'b00100, 32'h0000_1D80, "R6 misaligned GP");
        task_switched = 1'b1;
        report(6'b000000, 5'b00010, 32'h0000_1D80, "R9 R5 over R6");
        task_switched = 1'b0;
        write_csr(32'h0002_1D80); // misaligned mode on
        align_chk_en = 1'b1;
        report(6'b000100, 5'b01000, 32'h0002_1D80, "R7 align check AC");
        align_chk_en = 1'b0;
        report(6'b000100, 5'b10000, 32'h0002_1D84, "R7 no check, XF");
        report(6'b100000, 5'd0, 32'h0002_1DA4, "R7 no check, completes");
        rep_misaligned = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_sticky();
        t_unmasked();
        t_config();
        t_align();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule